// File: doc/BRIEF.md
# PCI Single-Data-Phase Memory Initiator

This block turns requests from an internal client into PCI initiator transactions. Each request becomes one memory read or one memory write with exactly one data phase of up to four bytes. The block drives the address phase, the byte enables, the write data, IRDY#, FRAME# and PAR. It watches DEVSEL#, TRDY# and STOP# from the target. When the transaction ends, it returns a one-cycle acknowledge, an error flag and the read data.

Arbitration is outside the block. The client holds `req_valid` and its fields steady until `req_ack`. The block starts only while its grant is low and the shared FRAME# and IRDY# wires are both high. Because only one data phase is ever used, FRAME# is released on the same clock that IRDY# is asserted. A parameter sets how many wait states the initiator inserts before asserting IRDY#. A second parameter sets the DEVSEL# deadline that triggers a master abort.

Top module: `pci_mem_master`

## Requirements
- R1: A transaction starts from idle only on a rising edge where `req_valid` is high, `gnt_n` is low, and `bus_frame_n` and `bus_irdy_n` are both high. On that edge the block drives `frame_n_o` low, `ad_o` to `req_addr`, `ad_oe` high, and `cbe_n_o` to the command: 4'b0110 for a read and 4'b0111 for a write.
- R2: PAR has even parity and is one clock late. On each clock after a clock where `ad_oe` was high, `par_oe` is high and `par_o` equals the XOR of all bits of the `ad_o` and `cbe_n_o` values from that earlier clock. On the clock after a clock where `ad_oe` was low, `par_oe` is low.
- R3: From the first data-phase clock, `cbe_n_o` carries the inverted byte enables (`~req_be`). On a write, `ad_o` carries `req_wdata` with `ad_oe` high. On a read, `ad_oe` is low.
- R4: `frame_n_o` rises on the same edge where `irdy_n_o` falls. The two outputs are never low together.
- R5: The initiator inserts exactly MASTER_WAIT wait states. `irdy_n_o` first goes low MASTER_WAIT+1 clocks after FRAME# assertion, and FRAME# stays low until then.
- R6: A data phase completes only on an edge where `irdy_n_o`, `trdy_n` and `devsel_n` are all low. Until that edge, IRDY# and the write data are held. Target wait states therefore only stretch the phase.
- R7: On the clock after completion, FRAME# and IRDY# are high, `ad_oe` is low, and `req_ack` is high for one clock with `req_err` low. On a read, `req_rdata` equals the `ad_i` value sampled at the completing edge.
- R8: If DEVSEL# is sampled high on each of the first DEVSEL_LIMIT edges after the FRAME#-asserting edge, the transaction ends on the DEVSEL_LIMIT-th edge. FRAME# and IRDY# go high, `req_ack` and `req_err` go high, and a read returns all ones.
- R9: Once DEVSEL# has been seen, an edge with STOP# low and TRDY# high ends the transaction without a transfer. `req_ack` and `req_err` go high, and a read returns all ones.
- R10: At least two idle clocks separate transactions. FRAME# cannot fall again until the second edge after the edge that raises `req_ack`, even if `req_valid` stays high.
- R11: After reset, FRAME# and IRDY# are high, `ad_oe`, `par_oe` and `req_ack` are low, and `cbe_n_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client request pending |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | DATA_W | Byte address |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle end-of-transaction pulse |
| req_err | output | 1 | Abort or stop without transfer, valid with req_ack |
| req_rdata | output | DATA_W | Read data, valid with req_ack |
| gnt_n | input | 1 | Bus grant from the arbiter, active low |
| bus_frame_n | input | 1 | Shared FRAME# wire as seen on the bus |
| bus_irdy_n | input | 1 | Shared IRDY# wire as seen on the bus |
| frame_n_o | output | 1 | FRAME# drive |
| irdy_n_o | output | 1 | IRDY# drive |
| ad_o | output | DATA_W | AD drive value |
| ad_i | input | DATA_W | AD bus sample |
| ad_oe | output | 1 | AD output enable |
| cbe_n_o | output | DATA_W/8 | C/BE# drive value |
| par_o | output | 1 | PAR drive value |
| par_oe | output | 1 | PAR output enable |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| stop_n | input | 1 | Target stop request, active low |

## Verification
The bench sweeps DEVSEL# arrival from the first edge up to one edge past the deadline, and TRDY# delay from zero to three extra edges. It runs every combination for both directions, with one initiator wait state. A design that counted the deadline one edge off would abort a target that arrives on the last allowed edge, or would wait one clock too long. A design that completed without checking DEVSEL# or IRDY# would return the wrong word from the `ad_i` stream. STOP# is swept both before and after IRDY# is asserted, to catch a design that drops the stop or reports it as a good transfer. A held request at the end checks that a design cannot skip the idle gap between transactions.

// File: rtl/pci_mm_pkg.sv
package pci_mm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_WAIT = 3'd2,
      ST_DATA = 3'd3,
      ST_TURN = 3'd4
   } mm_state_e;

   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pci_mm_parity.sv
module pci_mm_parity #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad,
   input  logic [BE_W-1:0]   cbe_n,
   input  logic              oe,
   output logic              par,
   output logic              par_oe
);

   if (BE_W * 8 != DATA_W) begin : g_bad_width
      $error("pci_mm_parity: BE_W must be DATA_W/8");
   end

   // even parity registered one clock behind the values it covers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par    <= 1'b0;
         par_oe <= 1'b0;
      end else begin
         par    <= ^{ad, cbe_n};
         par_oe <= oe;
      end
   end

endmodule

// File: rtl/pci_mm_devsel_timer.sv
module pci_mm_devsel_timer #(
   parameter int LIMIT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic devsel_n,
   output logic seen,
   output logic expired
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("pci_mm_devsel_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   // edges counted since FRAME# assertion; cnt_q == k-1 on edge k
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         seen  <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         seen  <= 1'b0;
      end else if (active) begin
         if (!devsel_n) seen <= 1'b1;
         else if (!seen && cnt_q != CW'(LIMIT - 1)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = active && devsel_n && !seen && (cnt_q == CW'(LIMIT - 1));

   a_r8_seen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && active && !start) |=> seen);

endmodule

// File: rtl/pci_mem_master.sv
module pci_mem_master
   import pci_mm_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int MASTER_WAIT  = 0,
   parameter int DEVSEL_LIMIT = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [DATA_W-1:0]     req_addr,
   input  logic [DATA_W/8-1:0]   req_be,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  req_ack,
   output logic                  req_err,
   output logic [DATA_W-1:0]     req_rdata,
   input  logic                  gnt_n,
   input  logic                  bus_frame_n,
   input  logic                  bus_irdy_n,
   output logic                  frame_n_o,
   output logic                  irdy_n_o,
   output logic [DATA_W-1:0]     ad_o,
   input  logic [DATA_W-1:0]     ad_i,
   output logic                  ad_oe,
   output logic [DATA_W/8-1:0]   cbe_n_o,
   output logic                  par_o,
   output logic                  par_oe,
   input  logic                  trdy_n,
   input  logic                  devsel_n,
   input  logic                  stop_n
);

   localparam int BE_W = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("pci_mem_master: DATA_W must be 32");
   end
   if (MASTER_WAIT < 0) begin : g_bad_wait
      $error("pci_mem_master: MASTER_WAIT must not be negative");
   end
   if (DEVSEL_LIMIT < 2) begin : g_bad_limit
      $error("pci_mem_master: DEVSEL_LIMIT must be at least 2");
   end

   mm_state_e         st_q;
   logic              frame_n_q, irdy_n_q, ad_oe_q, ack_q, err_q, wr_q;
   logic [DATA_W-1:0] ad_q, wdata_q, rdata_q;
   logic [BE_W-1:0]   cbe_n_q, be_q;

   logic go, tmo_active, tmo_seen, tmo_expired, wait_done;
   logic in_phase, fin_ok, fin_err;

   assign go         = (st_q == ST_IDLE) && req_valid && !gnt_n && bus_frame_n && bus_irdy_n;
   assign tmo_active = (st_q == ST_ADDR) || (st_q == ST_WAIT) || (st_q == ST_DATA);
   assign in_phase   = (st_q == ST_WAIT) || (st_q == ST_DATA);
   assign fin_ok     = (st_q == ST_DATA) && !irdy_n_q && !trdy_n && !devsel_n;
   assign fin_err    = !fin_ok && in_phase &&
                       ((!stop_n && trdy_n && (tmo_seen || !devsel_n)) || tmo_expired);

   // initiator wait-state counter, present only when waits are configured
   if (MASTER_WAIT == 0) begin : g_nowait
      assign wait_done = 1'b1;
   end else begin : g_wait
      localparam int WW = $clog2(MASTER_WAIT + 1);
      logic [WW-1:0] wcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            wcnt_q <= '0;
         else if (st_q == ST_ADDR)              wcnt_q <= '0;
         else if (st_q == ST_WAIT && !wait_done) wcnt_q <= wcnt_q + 1'b1;
      end
      assign wait_done = (wcnt_q == WW'(MASTER_WAIT - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         frame_n_q <= 1'b1;
         irdy_n_q  <= 1'b1;
         ad_oe_q   <= 1'b0;
         ad_q      <= '0;
         cbe_n_q   <= '1;
         ack_q     <= 1'b0;
         err_q     <= 1'b0;
         rdata_q   <= '0;
         wr_q      <= 1'b0;
         be_q      <= '0;
         wdata_q   <= '0;
      end else begin
         ack_q <= 1'b0;
         err_q <= 1'b0;
         if (fin_ok || fin_err) begin
            st_q      <= ST_TURN;
            frame_n_q <= 1'b1;
            irdy_n_q  <= 1'b1;
            ad_oe_q   <= 1'b0;
            cbe_n_q   <= '1;
            ack_q     <= 1'b1;
            err_q     <= fin_err;
            if (!wr_q) rdata_q <= fin_err ? '1 : ad_i;
         end else begin
            case (st_q)
               ST_IDLE: if (go) begin
                  st_q      <= ST_ADDR;
                  frame_n_q <= 1'b0;
                  ad_q      <= req_addr;
                  ad_oe_q   <= 1'b1;
                  cbe_n_q   <= req_write ? CMD_MEM_WR : CMD_MEM_RD;
                  wr_q      <= req_write;
                  be_q      <= req_be;
                  wdata_q   <= req_wdata;
               end
               ST_ADDR: begin
                  cbe_n_q <= ~be_q;
                  ad_oe_q <= wr_q;
                  if (wr_q) ad_q <= wdata_q;
                  if (MASTER_WAIT == 0) begin
                     st_q      <= ST_DATA;
                     irdy_n_q  <= 1'b0;
                     frame_n_q <= 1'b1;
                  end else begin
                     st_q <= ST_WAIT;
                  end
               end
               ST_WAIT: if (wait_done) begin
                  st_q      <= ST_DATA;
                  irdy_n_q  <= 1'b0;
                  frame_n_q <= 1'b1;
               end
               ST_DATA: ;
               ST_TURN: st_q <= ST_IDLE;
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   pci_mm_devsel_timer #(.LIMIT(DEVSEL_LIMIT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go),
      .active   (tmo_active),
      .devsel_n (devsel_n),
      .seen     (tmo_seen),
      .expired  (tmo_expired)
   );

   pci_mm_parity #(.DATA_W(DATA_W), .BE_W(BE_W)) u_par (
      .clk    (clk),
      .rst_n  (rst_n),
      .ad     (ad_q),
      .cbe_n  (cbe_n_q),
      .oe     (ad_oe_q),
      .par    (par_o),
      .par_oe (par_oe)
   );

   assign frame_n_o = frame_n_q;
   assign irdy_n_o  = irdy_n_q;
   assign ad_o      = ad_q;
   assign ad_oe     = ad_oe_q;
   assign cbe_n_o   = cbe_n_q;
   assign req_ack   = ack_q;
   assign req_err   = err_q;
   assign req_rdata = rdata_q;

   a_r1_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |-> $past(req_valid && !gnt_n && bus_frame_n && bus_irdy_n));

   a_r1_memory_command: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n_o) |-> (cbe_n_o == CMD_MEM_RD || cbe_n_o == CMD_MEM_WR));

   a_r4_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !(!frame_n_o && !irdy_n_o));

   a_r6_irdy_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n_o && (trdy_n || devsel_n) && stop_n && !tmo_expired) |=> !irdy_n_o);

   a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> frame_n_o);

endmodule

// File: tb/tb_pci_mem_master.sv
module tb_pci_mem_master;

   localparam int CLK_P = 10;
   localparam int MW    = 1;
   localparam int LIM   = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0, ad_i = '0;
   logic [3:0]  req_be = '0;
   logic        gnt_n = 1'b0, bus_frame_n = 1'b1, bus_irdy_n = 1'b1;
   logic        trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
   logic        req_ack, req_err, frame_n_o, irdy_n_o, ad_oe, par_o, par_oe;
   logic [31:0] req_rdata, ad_o;
   logic [3:0]  cbe_n_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P / 2) clk = ~clk;

   pci_mem_master #(.DATA_W(32), .MASTER_WAIT(MW), .DEVSEL_LIMIT(LIM)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata),
      .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
      .gnt_n(gnt_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
      .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o), .ad_o(ad_o), .ad_i(ad_i),
      .ad_oe(ad_oe), .cbe_n_o(cbe_n_o), .par_o(par_o), .par_oe(par_oe),
      .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // dv/tr/st: edge index (1 = first edge after FRAME# falls) at which the
   // target asserts DEVSEL#/TRDY#/STOP#; 0 means never
   task automatic run_txn(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                          input logic [31:0] wd, input int dv, input int tr, input int st,
                          input bit hold);
      int          t_end;
      bit          e_exp;
      logic [31:0] base, r_exp;
      logic        f_exp, i_exp;
      if (tr > 0) begin
         t_end = (tr > MW + 2) ? tr : MW + 2;
         e_exp = 1'b0;
      end else if (st > 0) begin
         t_end = st;
         e_exp = 1'b1;
      end else begin
         t_end = LIM;
         e_exp = 1'b1;
      end
      base  = wd ^ 32'h3C5A_0F00;
      r_exp = e_exp ? 32'hFFFF_FFFF : (base ^ 32'(t_end - 1));
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
      devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
      for (int k = 0; k <= t_end + 1; k++) begin
         @(negedge clk);
         f_exp = (k < ((MW + 1 < t_end) ? MW + 1 : t_end)) ? 1'b0 : 1'b1;
         i_exp = (k >= MW + 1 && k < t_end) ? 1'b0 : 1'b1;
         chk(frame_n_o == f_exp, "R4/R5", "frame_n", 64'(frame_n_o), 64'(f_exp));
         chk(irdy_n_o == i_exp, "R5/R6", "irdy_n", 64'(irdy_n_o), 64'(i_exp));
         chk(req_ack == (k == t_end), "R7", "req_ack", 64'(req_ack), 64'(k == t_end));
         if (k == 0) begin
            chk(ad_o == addr && ad_oe, "R1", "address", 64'(ad_o), 64'(addr));
            chk(cbe_n_o == (wr ? 4'b0111 : 4'b0110), "R1", "command",
                64'(cbe_n_o), 64'(wr ? 4'b0111 : 4'b0110));
         end
         if (k == 1) begin
            chk(par_oe && par_o == ^{addr, (wr ? 4'b0111 : 4'b0110)}, "R2", "address parity",
                64'({par_oe, par_o}), 64'({1'b1, ^{addr, (wr ? 4'b0111 : 4'b0110)}}));
            chk(cbe_n_o == ~be, "R3", "byte enables", 64'(cbe_n_o), 64'(~be));
            chk(ad_oe == wr, "R3", "ad_oe in data phase", 64'(ad_oe), 64'(wr));
            if (wr) chk(ad_o == wd, "R3", "write data", 64'(ad_o), 64'(wd));
         end
         if (k == 2) begin
            chk(par_oe == wr, "R2", "data par_oe", 64'(par_oe), 64'(wr));
            if (wr) chk(par_o == ^{wd, ~be}, "R2", "data parity", 64'(par_o), 64'(^{wd, ~be}));
         end
         if (k == t_end) begin
            chk(req_err == e_exp, e_exp ? "R8/R9" : "R7", "req_err", 64'(req_err), 64'(e_exp));
            chk(!ad_oe, "R7", "ad released", 64'(ad_oe), 64'd0);
            if (!wr) chk(req_rdata == r_exp, e_exp ? "R8/R9" : "R7", "read data",
                         64'(req_rdata), 64'(r_exp));
            if (!hold) req_valid = 1'b0;
         end
         if (k == t_end + 1)
            chk(!par_oe, "R2", "par_oe after release", 64'(par_oe), 64'd0);
         devsel_n = !(dv > 0 && k + 1 >= dv);
         trdy_n   = !(tr > 0 && k + 1 >= tr);
         stop_n   = !(st > 0 && k + 1 >= st);
         ad_i     = base ^ 32'(k);
      end
      devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(frame_n_o && irdy_n_o && !ad_oe && !par_oe && !req_ack && cbe_n_o == 4'hF,
          "R11", "reset state", 64'({frame_n_o, irdy_n_o, ad_oe, par_oe, req_ack, cbe_n_o}),
          64'({5'b11000, 4'hF}));
      rst_n = 1'b1;
      @(negedge clk);
      chk(frame_n_o && irdy_n_o, "R11", "idle after reset", 64'({frame_n_o, irdy_n_o}), 64'd3);

      // R1: no start without grant or while the bus is busy
      req_valid = 1'b1; gnt_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(frame_n_o, "R1", "no grant", 64'(frame_n_o), 64'd1);
      end
      gnt_n = 1'b0; bus_frame_n = 1'b0;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk(frame_n_o, "R1", "bus FRAME# busy", 64'(frame_n_o), 64'd1);
      end
      bus_frame_n = 1'b1; bus_irdy_n = 1'b0;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk(frame_n_o, "R1", "bus IRDY# busy", 64'(frame_n_o), 64'd1);
      end
      req_valid = 1'b0; bus_irdy_n = 1'b1;

      // R6/R7 sweep over DEVSEL# and TRDY# timing, R8 with DEVSEL# one edge late
      for (int wr = 0; wr < 2; wr++) begin
         for (int dv = 1; dv <= LIM; dv++) begin
            for (int ex = 0; ex < 4; ex++) begin
               run_txn(wr[0], 32'h1000_0000 + 32'(dv << 8) + 32'(ex << 4) + 32'(wr * 4),
                       4'((dv + ex * 3) | 1), 32'hC0DE_0000 ^ (32'(dv) * 32'h0101_0101) ^ 32'(ex),
                       dv, dv + ex, 0, 1'b0);
            end
         end
         run_txn(wr[0], 32'h2000_0040, 4'hF, 32'hDEAD_BEEF, LIM + 1, 0, 0, 1'b0); // R8
         // R9: target stop without transfer, before and after IRDY#
         for (int dv = 1; dv <= 3; dv++) begin
            for (int s = (dv < 2 ? 2 : dv); s <= LIM; s++) begin
               run_txn(wr[0], 32'h3000_0000 + 32'(s << 4), 4'b0110,
                       32'h1234_5678 + 32'(s), dv, 0, s, 1'b0);
            end
         end
      end

      // R10: request held across acknowledge
      run_txn(1'b1, 32'h4000_0000, 4'h3, 32'hA5A5_5A5A, 1, 2, 0, 1'b1);
      @(negedge clk);
      chk(!frame_n_o, "R10", "restart after idle gap", 64'(frame_n_o), 64'd0);
      req_valid = 1'b0;
      repeat (12) @(negedge clk);
      chk(frame_n_o && irdy_n_o, "R8", "aborted restart released bus",
          64'({frame_n_o, irdy_n_o}), 64'd3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule